// File: doc/BRIEF.md
# Banked CPU Register File

This block is the architectural register store of a small 16-bit processor core. It keeps seven registers in two copies: four data registers R0 to R3, two address registers A0 and A1, and the frame base FB. A bank bit in the flag word chooses which copy is live. Six control registers exist once and are seen from either bank. These are the static base SB, the interrupt stack pointer ISP, the user stack pointer USP, the flag word FLG, a 20-bit program counter PC and a 20-bit interrupt table base INTB.

One combinational read port and one clocked write port each take a register selector and an access size. A register can be reached as a byte, as a word or as a 32-bit pair. A separate strobe interface lets execution logic update individual flags, load the priority level and clear the debug flag when an interrupt is acknowledged. The block always presents the flag word and the stack pointer that the U flag selects. The decode logic, the arithmetic unit and the interrupt logic sit around it and use these ports directly.

Top module: `cpu_reg_file`

## Requirements
- R1: After reset, every register reads as zero, the flag word is 0x0000 (bank 0 live), and the active stack pointer output is zero.
- R2: Selector codes are R0=0, R1=1, R2=2, R3=3, A0=4, A1=5, FB=6, SB=7, ISP=8, USP=9, FLG=10, PC=11, INTB=12. Size codes are byte=0, word=1, long=2. A word access reaches registers 0 to 10. A byte access with selector 0, 1, 2 or 3 reaches R0 low, R0 high, R1 low and R1 high, and a byte write takes its data from bits 7:0.
- R3: A byte write to one half of R0 or R1 leaves the other half unchanged.
- R4: A long access with selector 0 reaches R2:R0, selector 1 reaches R3:R1 and selector 4 reaches A1:A0. In each case the first-named register is bits 31:16.
- R5: Flag bit 4 (B) picks the bank of R0 to R3, A0, A1 and FB for both ports. Each bank keeps its own contents.
- R6: SB, ISP, USP, PC and INTB are one shared copy and read the same from either bank.
- R7: The flag word holds C, D, Z, S, B, O, I and U at bits 0 to 7, and the priority level at bits 14:12. All other bits read as zero and ignore writes.
- R8: The stack pointer output shows ISP while U (bit 7) is 0 and USP while U is 1.
- R9: An interrupt acknowledge clears D (bit 1) at the next edge, whatever else writes the flag word.
- R10: When the per-flag update strobe or the level load hits a field in the same cycle as a register write to FLG, the strobe value wins for that field. Fields without a strobe take the written value.
- R11: PC and INTB are accessed only with long size, with 20 bits kept and read back zero-extended. Unsupported combinations are ignored on write and read as zero. These include word or byte access to PC or INTB, byte access to selectors above 3, long access to other selectors, and size code 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdSel | input | 4 | Read register selector |
| rdSize | input | 2 | Read access size |
| rdData | output | 32 | Read data, zero-extended |
| wrEn | input | 1 | Write enable |
| wrSel | input | 4 | Write register selector |
| wrSize | input | 2 | Write access size |
| wrData | input | 32 | Write data |
| flagMask | input | 8 | Per-flag update enables for bits 7:0 |
| flagVal | input | 8 | Values for flags with their enable set |
| iplLoad | input | 1 | Load the priority level field |
| iplVal | input | 3 | New priority level |
| intAck | input | 1 | Interrupt acknowledge, clears D |
| flagsOut | output | 16 | Current flag word |
| stackPtr | output | 16 | Active stack pointer |

## Verification
The register file is driven through word, byte and long patterns on the same registers. Reading back through each view shows whether lanes are routed and merged correctly, including the high word of every pair. Bank tests write distinct values in both banks and switch by a FLG write and by the strobe. They also read SB, which separates banked storage from shared storage. Flag patterns load all ones, write against a strobe, and combine an acknowledge with a set D. These show the reserved-bit masking, the priority between the strobe and the write port, and the stack pointer selection. Illegal size and selector pairs are followed by reads of the targeted registers to prove that nothing changed.

// File: rtl/cpu_reg_pkg.sv
package cpu_reg_pkg;
  localparam int DATA_W      = 16;
  localparam int LONG_W      = 2 * DATA_W;
  localparam int ADDR_W      = 20;
  localparam int NUM_BANKS   = 2;
  localparam int BANKED_REGS = 7;
  localparam int SEL_W       = 4;
  localparam int SIZE_W      = 2;
  localparam int FLAG_BITS   = 8;
  localparam int IPL_W       = 3;
  localparam int IPL_LSB     = 12;

  localparam int FLAG_D = 1;
  localparam int FLAG_B = 4;
  localparam int FLAG_U = 7;
  localparam logic [DATA_W-1:0] FLAG_KEEP = 16'h70FF;

  localparam logic [SIZE_W-1:0] SZ_BYTE = 2'd0;
  localparam logic [SIZE_W-1:0] SZ_WORD = 2'd1;
  localparam logic [SIZE_W-1:0] SZ_LONG = 2'd2;

  localparam logic [SEL_W-1:0] SEL_R0   = 4'd0;
  localparam logic [SEL_W-1:0] SEL_R1   = 4'd1;
  localparam logic [SEL_W-1:0] SEL_R2   = 4'd2;
  localparam logic [SEL_W-1:0] SEL_R3   = 4'd3;
  localparam logic [SEL_W-1:0] SEL_A0   = 4'd4;
  localparam logic [SEL_W-1:0] SEL_A1   = 4'd5;
  localparam logic [SEL_W-1:0] SEL_FB   = 4'd6;
  localparam logic [SEL_W-1:0] SEL_SB   = 4'd7;
  localparam logic [SEL_W-1:0] SEL_ISP  = 4'd8;
  localparam logic [SEL_W-1:0] SEL_USP  = 4'd9;
  localparam logic [SEL_W-1:0] SEL_FLG  = 4'd10;
  localparam logic [SEL_W-1:0] SEL_PC   = 4'd11;
  localparam logic [SEL_W-1:0] SEL_INTB = 4'd12;

  typedef struct packed {
    logic [BANKED_REGS-1:0] loWe;
    logic [BANKED_REGS-1:0] hiWe;
    logic [BANKED_REGS-1:0] useHi;
    logic                   sbWe;
    logic                   ispWe;
    logic                   uspWe;
    logic                   flgWe;
    logic                   pcWe;
    logic                   intbWe;
    logic [DATA_W-1:0]      laneLo;
    logic [DATA_W-1:0]      laneHi;
    logic [ADDR_W-1:0]      wide;
  } wrStrobe_t;
endpackage

// File: rtl/reg_wr_ctrl.sv
module reg_wr_ctrl
  import cpu_reg_pkg::*;
(
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [SIZE_W-1:0] wrSize,
  input  logic [LONG_W-1:0] wrData,
  output wrStrobe_t         strb
);
  always_comb begin
    strb        = '0;
    strb.laneLo = (wrSize == SZ_BYTE) ? {2{wrData[7:0]}} : wrData[DATA_W-1:0];
    strb.laneHi = wrData[LONG_W-1:DATA_W];
    strb.wide   = wrData[ADDR_W-1:0];
    if (wrEn) begin
      case (wrSize)
        SZ_BYTE: begin
          if (wrSel <= SEL_R3) begin
            if (wrSel[0]) strb.hiWe[{2'b00, wrSel[1]}] = 1'b1;
            else          strb.loWe[{2'b00, wrSel[1]}] = 1'b1;
          end
        end
        SZ_WORD: begin
          if (wrSel <= SEL_FB) begin
            strb.loWe[wrSel[2:0]] = 1'b1;
            strb.hiWe[wrSel[2:0]] = 1'b1;
          end
          strb.sbWe  = (wrSel == SEL_SB);
          strb.ispWe = (wrSel == SEL_ISP);
          strb.uspWe = (wrSel == SEL_USP);
          strb.flgWe = (wrSel == SEL_FLG);
        end
        SZ_LONG: begin
          case (wrSel)
            SEL_R0: begin
              strb.loWe[0] = 1'b1; strb.hiWe[0] = 1'b1;
              strb.loWe[2] = 1'b1; strb.hiWe[2] = 1'b1; strb.useHi[2] = 1'b1;
            end
            SEL_R1: begin
              strb.loWe[1] = 1'b1; strb.hiWe[1] = 1'b1;
              strb.loWe[3] = 1'b1; strb.hiWe[3] = 1'b1; strb.useHi[3] = 1'b1;
            end
            SEL_A0: begin
              strb.loWe[4] = 1'b1; strb.hiWe[4] = 1'b1;
              strb.loWe[5] = 1'b1; strb.hiWe[5] = 1'b1; strb.useHi[5] = 1'b1;
            end
            SEL_PC:   strb.pcWe   = 1'b1;
            SEL_INTB: strb.intbWe = 1'b1;
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/reg_store.sv
module reg_store
  import cpu_reg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  wrStrobe_t            strb,
  input  logic [FLAG_BITS-1:0] flagMask,
  input  logic [FLAG_BITS-1:0] flagVal,
  input  logic                 iplLoad,
  input  logic [IPL_W-1:0]     iplVal,
  input  logic                 intAck,
  input  logic [SEL_W-1:0]     rdSel,
  input  logic [SIZE_W-1:0]    rdSize,
  output logic [LONG_W-1:0]    rdData,
  output logic [DATA_W-1:0]    flagsOut,
  output logic [DATA_W-1:0]    stackPtr
);
  logic [DATA_W-1:0] bankReg [NUM_BANKS][BANKED_REGS];
  logic [DATA_W-1:0] sbReg, ispReg, uspReg, flgReg, flgNext;
  logic [ADDR_W-1:0] pcReg, intbReg;
  logic              bankSel;

  assign bankSel = flgReg[FLAG_B];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    for (genvar r = 0; r < BANKED_REGS; r++) begin : g_reg
      logic [DATA_W-1:0] src;
      logic              hit;
      assign src = strb.useHi[r] ? strb.laneHi : strb.laneLo;
      assign hit = (bankSel == 1'(b));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          bankReg[b][r] <= '0;
        end else if (hit) begin
          if (strb.loWe[r]) bankReg[b][r][7:0]        <= src[7:0];
          if (strb.hiWe[r]) bankReg[b][r][DATA_W-1:8] <= src[DATA_W-1:8];
        end
      end
    end
  end

  always_comb begin
    flgNext = flgReg;
    if (strb.flgWe) flgNext = strb.laneLo & FLAG_KEEP;
    for (int k = 0; k < FLAG_BITS; k++)
      if (flagMask[k]) flgNext[k] = flagVal[k];
    if (iplLoad) flgNext[IPL_LSB +: IPL_W] = iplVal;
    if (intAck)  flgNext[FLAG_D] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sbReg <= '0; ispReg <= '0; uspReg <= '0; flgReg <= '0;
      pcReg <= '0; intbReg <= '0;
    end else begin
      if (strb.sbWe)   sbReg   <= strb.laneLo;
      if (strb.ispWe)  ispReg  <= strb.laneLo;
      if (strb.uspWe)  uspReg  <= strb.laneLo;
      if (strb.pcWe)   pcReg   <= strb.wide;
      if (strb.intbWe) intbReg <= strb.wide;
      flgReg <= flgNext;
    end
  end

  always_comb begin
    rdData = '0;
    case (rdSize)
      SZ_BYTE: begin
        if (rdSel <= SEL_R3) begin
          if (rdSel[0]) rdData[7:0] = bankReg[bankSel][{2'b00, rdSel[1]}][DATA_W-1:8];
          else          rdData[7:0] = bankReg[bankSel][{2'b00, rdSel[1]}][7:0];
        end
      end
      SZ_WORD: begin
        if (rdSel <= SEL_FB) rdData[DATA_W-1:0] = bankReg[bankSel][rdSel[2:0]];
        else if (rdSel == SEL_SB)  rdData[DATA_W-1:0] = sbReg;
        else if (rdSel == SEL_ISP) rdData[DATA_W-1:0] = ispReg;
        else if (rdSel == SEL_USP) rdData[DATA_W-1:0] = uspReg;
        else if (rdSel == SEL_FLG) rdData[DATA_W-1:0] = flgReg;
      end
      SZ_LONG: begin
        case (rdSel)
          SEL_R0:   rdData = {bankReg[bankSel][2], bankReg[bankSel][0]};
          SEL_R1:   rdData = {bankReg[bankSel][3], bankReg[bankSel][1]};
          SEL_A0:   rdData = {bankReg[bankSel][5], bankReg[bankSel][4]};
          SEL_PC:   rdData[ADDR_W-1:0] = pcReg;
          SEL_INTB: rdData[ADDR_W-1:0] = intbReg;
          default: ;
        endcase
      end
      default: ;
    endcase
  end

  assign flagsOut = flgReg;
  assign stackPtr = flgReg[FLAG_U] ? uspReg : ispReg;
endmodule

// File: rtl/cpu_reg_file.sv
module cpu_reg_file
  import cpu_reg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [SEL_W-1:0]     rdSel,
  input  logic [SIZE_W-1:0]    rdSize,
  output logic [LONG_W-1:0]    rdData,
  input  logic                 wrEn,
  input  logic [SEL_W-1:0]     wrSel,
  input  logic [SIZE_W-1:0]    wrSize,
  input  logic [LONG_W-1:0]    wrData,
  input  logic [FLAG_BITS-1:0] flagMask,
  input  logic [FLAG_BITS-1:0] flagVal,
  input  logic                 iplLoad,
  input  logic [IPL_W-1:0]     iplVal,
  input  logic                 intAck,
  output logic [DATA_W-1:0]    flagsOut,
  output logic [DATA_W-1:0]    stackPtr
);
  wrStrobe_t strb;

  reg_wr_ctrl u_ctrl (
    .wrEn   (wrEn),
    .wrSel  (wrSel),
    .wrSize (wrSize),
    .wrData (wrData),
    .strb   (strb)
  );

  reg_store u_store (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .flagMask (flagMask),
    .flagVal  (flagVal),
    .iplLoad  (iplLoad),
    .iplVal   (iplVal),
    .intAck   (intAck),
    .rdSel    (rdSel),
    .rdSize   (rdSize),
    .rdData   (rdData),
    .flagsOut (flagsOut),
    .stackPtr (stackPtr)
  );
endmodule

// File: rtl/cpu_reg_file_chk.sv
module cpu_reg_file_chk (
  input logic        clk,
  input logic        rstN,
  input logic [3:0]  rdSel,
  input logic [1:0]  rdSize,
  input logic [31:0] rdData,
  input logic        wrEn,
  input logic [3:0]  wrSel,
  input logic [1:0]  wrSize,
  input logic [31:0] wrData,
  input logic [7:0]  flagMask,
  input logic [7:0]  flagVal,
  input logic        intAck,
  input logic [15:0] flagsOut,
  input logic [15:0] stackPtr
);
  // R9
  d_clear_on_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    intAck |=> !flagsOut[1]);

  // R7
  rsvd_flags_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagsOut & ~16'h70FF) == 16'h0000);

  // R10
  strobe_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|flagMask) |=> ((flagsOut[7:0] ^ $past(flagVal)) & $past(flagMask)
                     & ~{6'b0, $past(intAck), 1'b0}) == 8'h00);

  // R8
  isp_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSize == 2'd1 && wrSel == 4'd8 && !flagsOut[7] && !flagMask[7])
    |=> stackPtr == $past(wrData[15:0]));

  // R3
  hi_byte_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSize == 2'd0 && wrSel == 4'd1 && rdSel == 4'd0 && rdSize == 2'd1
     && !flagMask[4])
    |=> !($stable(rdSel) && $stable(rdSize))
        || rdData[15:0] == {$past(wrData[7:0]), $past(rdData[7:0])});
endmodule

bind cpu_reg_file cpu_reg_file_chk u_chk (
  .clk(clk), .rstN(rstN), .rdSel(rdSel), .rdSize(rdSize), .rdData(rdData),
  .wrEn(wrEn), .wrSel(wrSel), .wrSize(wrSize), .wrData(wrData),
  .flagMask(flagMask), .flagVal(flagVal), .intAck(intAck),
  .flagsOut(flagsOut), .stackPtr(stackPtr)
);

// File: tb/cpu_reg_file_bench.sv
module cpu_reg_file_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  rdSel = '0;
  logic [1:0]  rdSize = '0;
  logic [31:0] rdData;
  logic        wrEn = 1'b0;
  logic [3:0]  wrSel = '0;
  logic [1:0]  wrSize = '0;
  logic [31:0] wrData = '0;
  logic [7:0]  flagMask = '0;
  logic [7:0]  flagVal = '0;
  logic        iplLoad = 1'b0;
  logic [2:0]  iplVal = '0;
  logic        intAck = 1'b0;
  logic [15:0] flagsOut;
  logic [15:0] stackPtr;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } expItem_t;

  expItem_t sbq[$];
  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  cpu_reg_file u_cpu_reg_file (
    .clk(clk), .rstN(rstN), .rdSel(rdSel), .rdSize(rdSize), .rdData(rdData),
    .wrEn(wrEn), .wrSel(wrSel), .wrSize(wrSize), .wrData(wrData),
    .flagMask(flagMask), .flagVal(flagVal), .iplLoad(iplLoad), .iplVal(iplVal),
    .intAck(intAck), .flagsOut(flagsOut), .stackPtr(stackPtr)
  );

  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      expItem_t it;
      logic [31:0] act;
      it = sbq.pop_front();
      case (it.kind)
        0:       act = rdData;
        1:       act = {16'h0, flagsOut};
        default: act = {16'h0, stackPtr};
      endcase
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic clrCtl();
    wrEn = 1'b0; flagMask = '0; flagVal = '0;
    iplLoad = 1'b0; iplVal = '0; intAck = 1'b0;
  endtask

  task automatic wr(input logic [3:0] s, input logic [1:0] z, input logic [31:0] d);
    @(posedge clk); #1;
    clrCtl();
    wrEn = 1'b1; wrSel = s; wrSize = z; wrData = d;
  endtask

  task automatic wrFlag(input logic [15:0] d, input logic [7:0] m, input logic [7:0] v,
                        input logic ld, input logic [2:0] lv, input logic ack);
    @(posedge clk); #1;
    clrCtl();
    wrEn = 1'b1; wrSel = 4'd10; wrSize = 2'd1; wrData = {16'h0, d};
    flagMask = m; flagVal = v; iplLoad = ld; iplVal = lv; intAck = ack;
  endtask

  task automatic strobe(input logic [7:0] m, input logic [7:0] v, input logic ack);
    @(posedge clk); #1;
    clrCtl();
    flagMask = m; flagVal = v; intAck = ack;
  endtask

  task automatic rd(input logic [3:0] s, input logic [1:0] z, input logic [31:0] e,
                    input string tag);
    @(posedge clk); #1;
    clrCtl();
    rdSel = s; rdSize = z;
    sbq.push_back('{0, e, tag});
  endtask

  task automatic chkFlags(input logic [15:0] e, input string tag);
    @(posedge clk); #1;
    clrCtl();
    sbq.push_back('{1, {16'h0, e}, tag});
  endtask

  task automatic chkSp(input logic [15:0] e, input string tag);
    @(posedge clk); #1;
    clrCtl();
    sbq.push_back('{2, {16'h0, e}, tag});
  endtask

  task automatic finishRun();
    @(posedge clk); #1;
    clrCtl();
    @(negedge clk); #1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state
    rd(4'd0, 2'd1, 32'h0, "R1");
    chkFlags(16'h0000, "R1");
    chkSp(16'h0000, "R1");

    // R2: word and byte views
    wr(4'd0, 2'd1, 32'h1234);
    rd(4'd0, 2'd1, 32'h1234, "R2");
    rd(4'd0, 2'd0, 32'h34, "R2");
    rd(4'd1, 2'd0, 32'h12, "R2");

    // R3: byte write keeps the other half
    wr(4'd1, 2'd0, 32'hAB);
    rd(4'd0, 2'd1, 32'hAB34, "R3");
    wr(4'd0, 2'd0, 32'hCD);
    rd(4'd0, 2'd1, 32'hABCD, "R3");

    // R4: long pairs
    wr(4'd0, 2'd2, 32'hDEADBEEF);
    rd(4'd2, 2'd1, 32'hDEAD, "R4");
    rd(4'd0, 2'd2, 32'hDEADBEEF, "R4");
    wr(4'd1, 2'd2, 32'h11112222);
    rd(4'd3, 2'd1, 32'h1111, "R4");
    rd(4'd1, 2'd1, 32'h2222, "R4");
    wr(4'd4, 2'd2, 32'h5555AAAA);
    rd(4'd5, 2'd1, 32'h5555, "R4");
    rd(4'd4, 2'd2, 32'h5555AAAA, "R4");

    // R5 / R6: banks and shared registers
    wr(4'd10, 2'd1, 32'h0010);
    chkFlags(16'h0010, "R5");
    rd(4'd0, 2'd1, 32'h0, "R5");
    wr(4'd0, 2'd1, 32'h7777);
    wr(4'd6, 2'd1, 32'h0F0F);
    wr(4'd7, 2'd1, 32'h3333);
    wr(4'd10, 2'd1, 32'h0000);
    rd(4'd0, 2'd1, 32'hBEEF, "R5");
    rd(4'd6, 2'd1, 32'h0, "R5");
    rd(4'd7, 2'd1, 32'h3333, "R6");
    strobe(8'h10, 8'h10, 1'b0);
    rd(4'd0, 2'd1, 32'h7777, "R5");
    rd(4'd6, 2'd1, 32'h0F0F, "R5");
    rd(4'd7, 2'd1, 32'h3333, "R6");
    rd(4'd4, 2'd2, 32'h0, "R5");

    // R7: reserved flag bits
    wr(4'd10, 2'd1, 32'hFFFF);
    chkFlags(16'h70FF, "R7");
    wr(4'd10, 2'd1, 32'h0000);

    // R8: active stack pointer
    wr(4'd8, 2'd1, 32'h1000);
    wr(4'd9, 2'd1, 32'h2000);
    chkSp(16'h1000, "R8");
    rd(4'd8, 2'd1, 32'h1000, "R6");
    wr(4'd10, 2'd1, 32'h0080);
    chkSp(16'h2000, "R8");

    // R9: acknowledge clears D
    wr(4'd10, 2'd1, 32'h0082);
    chkFlags(16'h0082, "R9");
    strobe(8'h00, 8'h00, 1'b1);
    chkFlags(16'h0080, "R9");
    wrFlag(16'h0082, 8'h00, 8'h00, 1'b0, 3'd0, 1'b1);
    chkFlags(16'h0080, "R9");

    // R10: strobe beats register write
    wrFlag(16'h0005, 8'h01, 8'h00, 1'b0, 3'd0, 1'b0);
    chkFlags(16'h0004, "R10");
    wrFlag(16'h7000, 8'h00, 8'h00, 1'b1, 3'd2, 1'b0);
    chkFlags(16'h2000, "R10");

    // R11: PC / INTB and unsupported combinations
    wr(4'd11, 2'd2, 32'hFFFFFFFF);
    rd(4'd11, 2'd2, 32'h000FFFFF, "R11");
    wr(4'd11, 2'd1, 32'h1234);
    rd(4'd11, 2'd2, 32'h000FFFFF, "R11");
    rd(4'd11, 2'd1, 32'h0, "R11");
    wr(4'd12, 2'd2, 32'h000ABCDE);
    rd(4'd12, 2'd2, 32'h000ABCDE, "R11");
    wr(4'd4, 2'd0, 32'h99);
    rd(4'd4, 2'd1, 32'hAAAA, "R11");
    rd(4'd4, 2'd0, 32'h0, "R11");
    wr(4'd3, 2'd3, 32'hFFFFFFFF);
    rd(4'd3, 2'd1, 32'h1111, "R11");

    done = 1'b1;
    finishRun();
  end
endmodule